// File: doc/BRIEF.md
# Extended Multiply/Divide Unit

This block is a multi-cycle arithmetic engine for four wide operations on three 16-bit working registers, called D, X and Y here. It covers a signed 16-by-16 divide, an unsigned 32-by-16 divide, a signed 32-by-16 divide and a signed 16-by-16 multiply. The register file outside the block supplies the three register values, the current condition flags and an operation code on a one-cycle `start`. Some cycles later the block returns the new register values, one write enable per register and the new N, Z, V and C flags, all qualified by a one-cycle `done`.

The divides use a restoring shift-subtract loop that yields one quotient bit per cycle. The loop works on magnitudes, and the signs are applied at the end, so the quotient truncates toward zero and the remainder carries the sign of the dividend. The multiply is a shift-add loop over magnitudes, one multiplier bit per cycle, with the sign applied at the end. A divisor of zero is detected at start and skips the loop entirely.

Top module: `xmd_unit`

## Requirements
- R1: Operation code 0 is the signed 16/16 divide. The dividend is D and the divisor is X, both two's complement. The quotient is truncated toward zero and goes to X. The remainder has the sign of the dividend and goes to D. Y is not written.
- R2: Operation code 1 is the unsigned 32/16 divide. The dividend is {Y,D} with Y as the upper half, and the divisor is X. The low 16 bits of the quotient go to Y and the remainder goes to D. V is 1 exactly when the quotient exceeds 65535.
- R3: Operation code 2 is the signed 32/16 divide. It uses the same register mapping as R2, with all operands in two's complement. The quotient truncates toward zero and the remainder has the sign of the dividend. V is 1 exactly when the true quotient lies outside -32768..32767.
- R4: A divide (codes 0, 1, 2) with X equal to zero sets C. It keeps N, Z and V from `flags_in`, raises no write enable, and presents D, X and Y unchanged on the outputs.
- R5: A divide with a non-zero divisor clears C. It sets Z exactly when the full quotient is zero and sets N to bit 15 of the quotient.
- R6: Operation code 3 is the signed multiply D times Y. The upper 16 bits of the product go to Y and the lower 16 bits go to D. Z is 1 when the 32-bit product is zero, N is product bit 31, C is product bit 15, and V is copied from `flags_in`.
- R7: `done` rises a fixed number of clock edges after the edge that samples `start`: 17 for the multiply, 33 for a divide, and 1 for a divide by zero.
- R8: `busy` is high from the cycle after the accepted start up to, but not including, the cycle in which `done` pulses. `done` lasts exactly one cycle, and write enables are only ever high together with `done`. An output for a register that is not written shows that register's value as captured at start.
- R9: A `start` that arrives while `busy` is high is ignored. The running operation completes with its own operands and latency, and no second `done` follows.
- R10: After reset, `busy`, `done` and all write enables are low.
- R11: The flag bus is ordered {N,Z,V,C}, with N in bit 3 and C in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; sampled only when idle |
| op | input | 2 | Operation code (0 sdiv16, 1 udiv32, 2 sdiv32, 3 smul16) |
| d_in | input | 16 | Current D register |
| x_in | input | 16 | Current X register |
| y_in | input | 16 | Current Y register |
| flags_in | input | 4 | Current flags {N,Z,V,C} |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| d_out | output | 16 | New D value |
| x_out | output | 16 | New X value |
| y_out | output | 16 | New Y value |
| d_we | output | 1 | Write D (only with done) |
| x_we | output | 1 | Write X (only with done) |
| y_we | output | 1 | Write Y (only with done) |
| flags_out | output | 4 | New flags {N,Z,V,C} |

## Verification
The bench targets the sign corners of division. It drives all four sign combinations of dividend and divisor, and a design that rounded toward minus infinity or gave the remainder the divisor's sign would return a wrong X or D. It drives -32768 / -1 in both signed forms and -2^31 / -1. A design that computed V from the stored 16 bits instead of the true quotient would miss the overflow there, and it would also report Z wrongly when the low 16 bits of a large quotient are zero. It drives a divide by zero with the incoming flags deliberately set, so a design that cleared N, Z or V, wrote a register or ran the full loop would be caught. It also starts a second operation mid-flight to expose a design that restarts or queues.

// File: rtl/xmd_pkg.sv
package xmd_pkg;

  typedef enum logic [1:0] {
    OP_SDIV16 = 2'd0,
    OP_UDIV32 = 2'd1,
    OP_SDIV32 = 2'd2,
    OP_SMUL16 = 2'd3
  } xmd_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } xmd_state_e;

  // Flag bus bit positions (R11)
  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_V = 1;
  localparam int FLG_C = 0;

endpackage

// File: rtl/xmd_div_core.sv
module xmd_div_core #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [NUM_W-1:0] quo_o,
  output logic [DEN_W-1:0] rem_o
);

  logic [DEN_W:0]   rem_q, rem_d;
  logic [NUM_W-1:0] quo_q, quo_d;
  logic [DEN_W-1:0] den_q, den_d;
  logic [DEN_W:0]   shifted;
  logic [DEN_W+1:0] trial;

  // One restoring step: bring in the next dividend bit, try a subtract.
  always_comb begin
    shifted = {rem_q[DEN_W-1:0], quo_q[NUM_W-1]};
    trial   = {1'b0, shifted} - {2'b00, den_q};
    rem_d   = rem_q;
    quo_d   = quo_q;
    den_d   = den_q;
    if (load) begin
      rem_d = '0;
      quo_d = num_i;
      den_d = den_i;
    end else if (step) begin
      if (!trial[DEN_W+1]) begin
        rem_d = trial[DEN_W:0];
        quo_d = {quo_q[NUM_W-2:0], 1'b1};
      end else begin
        rem_d = shifted;
        quo_d = {quo_q[NUM_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      den_q <= '0;
    end else if (load || step) begin
      rem_q <= rem_d;
      quo_q <= quo_d;
      den_q <= den_d;
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q[DEN_W-1:0];

  // R1/R2/R3: the partial remainder never reaches the divisor once below it
  a_r1_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && den_q != '0 && rem_q < {1'b0, den_q}) |=> (rem_q < {1'b0, den_q}));

endmodule

// File: rtl/xmd_mul_core.sv
module xmd_mul_core #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);

  logic [W-1:0] hi_q, hi_d;
  logic [W-1:0] lo_q, lo_d;
  logic [W-1:0] mc_q, mc_d;
  logic [W:0]   sum;

  // Add the multiplicand when the current multiplier bit is set, shift right.
  always_comb begin
    sum  = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mc_q} : '0);
    hi_d = hi_q;
    lo_d = lo_q;
    mc_d = mc_q;
    if (load) begin
      hi_d = '0;
      lo_d = b_i;
      mc_d = a_i;
    end else if (step) begin
      hi_d = sum[W:1];
      lo_d = {sum[0], lo_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
      mc_q <= '0;
    end else if (load || step) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
      mc_q <= mc_d;
    end
  end

  assign prod_o = {hi_q, lo_q};

  // R6: the multiplicand is frozen while stepping
  a_r6_mcand_held: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> $stable(mc_q));

endmodule

// File: rtl/xmd_unit.sv
module xmd_unit
  import xmd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] d_in,
  input  logic [DATA_W-1:0] x_in,
  input  logic [DATA_W-1:0] y_in,
  input  logic [3:0]        flags_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] d_out,
  output logic [DATA_W-1:0] x_out,
  output logic [DATA_W-1:0] y_out,
  output logic              d_we,
  output logic              x_we,
  output logic              y_we,
  output logic [3:0]        flags_out
);

  localparam int NUM_W     = 2 * DATA_W;
  localparam int DIV_STEPS = NUM_W;
  localparam int MUL_STEPS = DATA_W;
  localparam int CNT_W     = $clog2(DIV_STEPS + 1);
  localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(DIV_STEPS - 1);
  localparam logic [CNT_W-1:0] MUL_LAST = CNT_W'(MUL_STEPS - 1);
  localparam logic [NUM_W-1:0] POS_MAX  = NUM_W'((64'd1 << (DATA_W - 1)) - 64'd1);
  localparam logic [NUM_W-1:0] NEG_MAX  = NUM_W'(64'd1 << (DATA_W - 1));

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Control and captured operand state
  xmd_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  xmd_op_e           op_q, op_d;
  logic              qneg_q, qneg_d;
  logic              rneg_q, rneg_d;
  logic [DATA_W-1:0] dcap_q, xcap_q, ycap_q;
  logic [3:1]        fcap_q;

  // Result registers
  logic              done_q, done_d;
  logic              dwe_q, dwe_d, xwe_q, xwe_d, ywe_q, ywe_d;
  logic [DATA_W-1:0] dout_q, dout_d, xout_q, xout_d, yout_q, yout_d;
  logic [3:0]        fout_q, fout_d;

  // Operand preparation at start
  xmd_op_e           op_in;
  logic              accept, is_div_in, div_zero_in;
  logic [NUM_W-1:0]  wide_in, wide_mag, num_mag;
  logic [DATA_W-1:0] d_mag, x_mag, y_mag, den_mag, ma_mag, mb_mag;
  logic              qneg_in, rneg_in;

  always_comb begin
    op_in       = xmd_op_e'(op);
    accept      = start && (state_q == ST_IDLE);
    is_div_in   = (op_in != OP_SMUL16);
    div_zero_in = (x_in == '0);
    wide_in     = {y_in, d_in};
    wide_mag    = wide_in[NUM_W-1] ? -wide_in : wide_in;
    d_mag       = d_in[DATA_W-1] ? -d_in : d_in;
    x_mag       = x_in[DATA_W-1] ? -x_in : x_in;
    y_mag       = y_in[DATA_W-1] ? -y_in : y_in;
    num_mag     = {{DATA_W{1'b0}}, d_mag};
    den_mag     = x_mag;
    qneg_in     = 1'b0;
    rneg_in     = 1'b0;
    ma_mag      = d_mag;
    mb_mag      = y_mag;
    case (op_in)
      OP_SDIV16: begin
        qneg_in = d_in[DATA_W-1] ^ x_in[DATA_W-1];
        rneg_in = d_in[DATA_W-1];
      end
      OP_UDIV32: begin
        num_mag = wide_in;
        den_mag = x_in;
      end
      OP_SDIV32: begin
        num_mag = wide_mag;
        qneg_in = y_in[DATA_W-1] ^ x_in[DATA_W-1];
        rneg_in = y_in[DATA_W-1];
      end
      default: begin
        qneg_in = d_in[DATA_W-1] ^ y_in[DATA_W-1];
      end
    endcase
  end

  // Datapath cores
  logic             div_load, div_step, mul_load, mul_step;
  logic [NUM_W-1:0] quo_mag, prod_mag;
  logic [DATA_W-1:0] rem_mag;

  assign div_load = accept && is_div_in;
  assign mul_load = accept && !is_div_in;
  assign div_step = (state_q == ST_RUN) && (op_q != OP_SMUL16);
  assign mul_step = (state_q == ST_RUN) && (op_q == OP_SMUL16);

  xmd_div_core #(.NUM_W(NUM_W), .DEN_W(DATA_W)) u_div (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (div_load),
    .step  (div_step),
    .num_i (num_mag),
    .den_i (den_mag),
    .quo_o (quo_mag),
    .rem_o (rem_mag)
  );

  xmd_mul_core #(.W(DATA_W)) u_mul (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load   (mul_load),
    .step   (mul_step),
    .a_i    (ma_mag),
    .b_i    (mb_mag),
    .prod_o (prod_mag)
  );

  // Sign correction and flag formation
  logic [DATA_W-1:0] q_low, r_sgn;
  logic [NUM_W-1:0]  p_sgn;
  logic              ovf_s, ovf_u, dz_fin;

  always_comb begin
    q_low  = qneg_q ? -quo_mag[DATA_W-1:0] : quo_mag[DATA_W-1:0];
    r_sgn  = rneg_q ? -rem_mag : rem_mag;
    p_sgn  = qneg_q ? -prod_mag : prod_mag;
    ovf_s  = qneg_q ? (quo_mag > NEG_MAX) : (quo_mag > POS_MAX);
    ovf_u  = |quo_mag[NUM_W-1:DATA_W];
    dz_fin = (op_q != OP_SMUL16) && (xcap_q == '0);
  end

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    op_d    = op_q;
    qneg_d  = qneg_q;
    rneg_d  = rneg_q;
    done_d  = 1'b0;
    dwe_d   = 1'b0;
    xwe_d   = 1'b0;
    ywe_d   = 1'b0;
    dout_d  = dout_q;
    xout_d  = xout_q;
    yout_d  = yout_q;
    fout_d  = fout_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          op_d    = op_in;
          qneg_d  = qneg_in;
          rneg_d  = rneg_in;
          cnt_d   = '0;
          state_d = (is_div_in && div_zero_in) ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == ((op_q == OP_SMUL16) ? MUL_LAST : DIV_LAST)) begin
          state_d = ST_FIN;
        end
      end
      ST_FIN: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        dout_d  = dcap_q;
        xout_d  = xcap_q;
        yout_d  = ycap_q;
        fout_d  = {fcap_q, 1'b0};
        if (dz_fin) begin
          fout_d[FLG_C] = 1'b1;
        end else if (op_q == OP_SMUL16) begin
          dwe_d         = 1'b1;
          ywe_d         = 1'b1;
          dout_d        = p_sgn[DATA_W-1:0];
          yout_d        = p_sgn[NUM_W-1:DATA_W];
          fout_d[FLG_N] = p_sgn[NUM_W-1];
          fout_d[FLG_Z] = (p_sgn == '0);
          fout_d[FLG_C] = p_sgn[DATA_W-1];
        end else begin
          dwe_d         = 1'b1;
          dout_d        = r_sgn;
          fout_d[FLG_N] = q_low[DATA_W-1];
          fout_d[FLG_Z] = (quo_mag == '0);
          fout_d[FLG_V] = (op_q == OP_UDIV32) ? ovf_u : ovf_s;
          fout_d[FLG_C] = 1'b0;
          if (op_q == OP_SDIV16) begin
            xwe_d  = 1'b1;
            xout_d = q_low;
          end else begin
            ywe_d  = 1'b1;
            yout_d = q_low;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      op_q    <= OP_SDIV16;
      qneg_q  <= 1'b0;
      rneg_q  <= 1'b0;
      done_q  <= 1'b0;
      dwe_q   <= 1'b0;
      xwe_q   <= 1'b0;
      ywe_q   <= 1'b0;
      dout_q  <= '0;
      xout_q  <= '0;
      yout_q  <= '0;
      fout_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      op_q    <= op_d;
      qneg_q  <= qneg_d;
      rneg_q  <= rneg_d;
      done_q  <= done_d;
      dwe_q   <= dwe_d;
      xwe_q   <= xwe_d;
      ywe_q   <= ywe_d;
      dout_q  <= dout_d;
      xout_q  <= xout_d;
      yout_q  <= yout_d;
      fout_q  <= fout_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dcap_q <= '0;
      xcap_q <= '0;
      ycap_q <= '0;
      fcap_q <= '0;
    end else if (accept) begin
      dcap_q <= d_in;
      xcap_q <= x_in;
      ycap_q <= y_in;
      fcap_q <= flags_in[3:1];
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign d_we      = dwe_q;
  assign x_we      = xwe_q;
  assign y_we      = ywe_q;
  assign d_out     = dout_q;
  assign x_out     = xout_q;
  assign y_out     = yout_q;
  assign flags_out = fout_q;

  // R8: done is a single-cycle strobe
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: busy has dropped by the done cycle
  a_r8_busy_low_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8: write enables only accompany done
  a_r8_we_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (d_we || x_we || y_we) |-> done);

  // R9: busy ends only through done
  a_r9_busy_to_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  // R9: the captured operation is frozen while running
  a_r9_op_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(op_q));

  // R4: a finished operation that writes nothing is a divide by zero, with C set
  a_r4_dz_sets_c: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !d_we) |-> flags_out[FLG_C]);

  // R5: a completed 16/16 divide always clears C
  a_r5_c_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (done && x_we) |-> !flags_out[FLG_C]);

endmodule

// File: tb/test_xmd_unit.sv
`timescale 1ns/1ps
module test_xmd_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  op_i;
  logic [15:0] d_i, x_i, y_i;
  logic [3:0]  f_i;
  logic        busy, done, d_we, x_we, y_we;
  logic [15:0] d_o, x_o, y_o;
  logic [3:0]  f_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;   // 250 MHz

  xmd_unit i_xmd_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op        (op_i),
    .d_in      (d_i),
    .x_in      (x_i),
    .y_in      (y_i),
    .flags_in  (f_i),
    .busy      (busy),
    .done      (done),
    .d_out     (d_o),
    .x_out     (x_o),
    .y_out     (y_o),
    .d_we      (d_we),
    .x_we      (x_we),
    .y_we      (y_we),
    .flags_out (f_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Reference model built from the requirements
  task automatic model(input logic [1:0] op, input logic [15:0] d, x, y, input logic [3:0] f,
                       output logic [15:0] ed, ex, ey, output logic [2:0] ewe,
                       output logic [3:0] ef, output int lat);
    longint a, b, q, r, p;
    bit ovf;
    ed = d; ex = x; ey = y; ewe = 3'b000; ef = f;
    if (op != 2'd3 && x == 16'h0) begin
      ef[0] = 1'b1;                     // R4
      lat = 1;
    end else if (op == 2'd3) begin      // R6
      p = longint'($signed(d)) * longint'($signed(y));
      ed = p[15:0]; ey = p[31:16]; ewe = 3'b101;
      ef = {p[31], p[31:0] == 32'h0, f[1], p[15]};
      lat = 17;
    end else begin
      if (op == 2'd0) begin a = longint'($signed(d)); b = longint'($signed(x)); end
      else if (op == 2'd1) begin a = longint'({32'h0, y, d}); b = longint'({48'h0, x}); end
      else begin a = longint'($signed({y, d})); b = longint'($signed(x)); end
      q = a / b;
      r = a % b;
      ovf = (op == 2'd1) ? (q > 65535) : (q > 32767 || q < -32768);
      ef = {q[15], q == 0, ovf, 1'b0};  // R5
      ed = r[15:0];
      if (op == 2'd0) begin ex = q[15:0]; ewe = 3'b110; end
      else begin ey = q[15:0]; ewe = 3'b101; end
      lat = 33;
    end
  endtask

  task automatic run_op(input string req, input logic [1:0] op, input logic [15:0] d, x, y,
                        input logic [3:0] f, input bit mid_start);
    logic [15:0] ed, ex, ey;
    logic [2:0]  ewe;
    logic [3:0]  ef;
    int lat;
    int cyc;
    bit busy_ok;
    model(op, d, x, y, f, ed, ex, ey, ewe, ef, lat);
    @(negedge clk);
    start = 1'b1; op_i = op; d_i = d; x_i = x; y_i = y; f_i = f;
    @(negedge clk);
    start = 1'b0;
    d_i = ~d; x_i = ~x; y_i = ~y; f_i = ~f;   // operands must be captured
    cyc = 0;
    busy_ok = busy;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
      start = mid_start && (cyc == 3);
      if (start) op_i = op ^ 2'd1;
      if (!done && !busy) busy_ok = 1'b0;
    end
    start = 1'b0;
    check(cyc == lat, "R7", {req, " latency"}, cyc, lat);
    check(busy_ok, "R8", {req, " busy while running"}, busy_ok, 1);
    check(!busy, "R8", {req, " busy low at done"}, busy, 0);
    check(d_o == ed, req, "d_out", d_o, ed);
    check(x_o == ex, req, "x_out", x_o, ex);
    check(y_o == ey, req, "y_out", y_o, ey);
    check({d_we, x_we, y_we} == ewe, req, "write enables {d,x,y}", {d_we, x_we, y_we}, ewe);
    check(f_o == ef, req, "flags {N,Z,V,C}", f_o, ef);
    @(negedge clk);
    check(!done && !d_we && !x_we && !y_we, "R8", {req, " done single cycle"},
          {done, d_we, x_we, y_we}, 0);
  endtask

  task automatic t_reset();
    check(!busy && !done, "R10", "busy/done after reset", {busy, done}, 0);
    check(!d_we && !x_we && !y_we, "R10", "write enables after reset", {d_we, x_we, y_we}, 0);
  endtask

  task automatic t_sdiv16();
    run_op("R1", 2'd0, 16'd100, 16'd7, 16'h1234, 4'b0000, 1'b0);
    run_op("R1", 2'd0, -16'sd100, 16'd7, 16'h0, 4'b0010, 1'b0);
    run_op("R1", 2'd0, 16'd100, -16'sd7, 16'h0, 4'b0000, 1'b0);
    run_op("R1", 2'd0, -16'sd100, -16'sd7, 16'h0, 4'b1111, 1'b0);
    run_op("R1", 2'd0, 16'h8000, 16'hFFFF, 16'h0, 4'b0000, 1'b0);   // overflow
    run_op("R5", 2'd0, 16'd3, 16'd5, 16'h0, 4'b1001, 1'b0);         // zero quotient
    run_op("R5", 2'd0, 16'd0, -16'sd5, 16'h0, 4'b0000, 1'b0);
  endtask

  task automatic t_udiv32();
    run_op("R2", 2'd1, 16'h0000, 16'd2, 16'h0001, 4'b0000, 1'b0);    // 0x8000, N
    run_op("R2", 2'd1, 16'h0000, 16'd1, 16'h0010, 4'b0000, 1'b0);    // V, low half 0
    run_op("R2", 2'd1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 4'b0000, 1'b0);
    run_op("R2", 2'd1, 16'd1000, 16'd33, 16'h0000, 4'b0110, 1'b0);
  endtask

  task automatic t_sdiv32();
    run_op("R3", 2'd2, 16'h7960, 16'd7, 16'hFFFE, 4'b0000, 1'b0);    // -100000/7
    run_op("R3", 2'd2, 16'h0000, 16'hFFFF, 16'h8000, 4'b0000, 1'b0); // -2^31/-1
    run_op("R3", 2'd2, 16'h86A0, 16'd2, 16'h0001, 4'b0000, 1'b0);    // 50000
    run_op("R3", 2'd2, 16'h0000, 16'd2, 16'hFFFF, 4'b0010, 1'b0);    // -32768 fits
    run_op("R3", 2'd2, 16'h8000, 16'hFFFF, 16'hFFFF, 4'b0000, 1'b0); // +32768 overflow
    run_op("R3", 2'd2, 16'hFFF9, 16'd3, 16'hFFFF, 4'b0000, 1'b0);    // -7/3
  endtask

  task automatic t_div_zero();
    run_op("R4", 2'd0, 16'h1111, 16'h0, 16'h2222, 4'b1110, 1'b0);
    run_op("R4", 2'd1, 16'h3333, 16'h0, 16'h4444, 4'b0100, 1'b0);
    run_op("R4", 2'd2, 16'h5555, 16'h0, 16'h6666, 4'b1010, 1'b0);
  endtask

  task automatic t_smul();
    run_op("R6", 2'd3, 16'd3, 16'h9999, 16'd4, 4'b0010, 1'b0);
    run_op("R6", 2'd3, -16'sd3, 16'h0, 16'd4, 4'b0000, 1'b0);
    run_op("R6", 2'd3, 16'h8000, 16'h0, 16'h8000, 4'b0000, 1'b0);
    run_op("R6", 2'd3, 16'd0, 16'h0, 16'hBEEF, 4'b0011, 1'b0);
    run_op("R6", 2'd3, 16'h00FF, 16'h0, 16'h0100, 4'b0000, 1'b0);   // C from bit 15
    run_op("R11", 2'd3, 16'hFFFF, 16'h0, 16'h0001, 4'b0000, 1'b0);
  endtask

  task automatic t_busy_ignore();
    bit extra;
    run_op("R9", 2'd3, 16'd1234, 16'h0, -16'sd56, 4'b0000, 1'b1);
    run_op("R9", 2'd1, 16'h5678, 16'd9, 16'h0012, 4'b0000, 1'b1);
    extra = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (done || busy) extra = 1'b1;
    end
    check(!extra, "R9", "no second operation after ignored start", extra, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; op_i = 2'd0;
    d_i = '0; x_i = '0; y_i = '0; f_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_sdiv16();
    t_udiv32();
    t_sdiv32();
    t_div_zero();
    t_smul();
    t_busy_ignore();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    #400000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule